// File: doc/BRIEF.md
# Disk PIO Sector Transfer Controller

A single-channel control engine for a parallel disk interface operated in programmed I/O mode. A host talks to it through a byte-wide register file: a data port, a sector-count register, three LBA bytes, a device/head register that selects the drive, a command/status location, and an alternate-status/control location. The engine accepts multi-sector read and write commands. Each sector passes through an internal sector buffer. Between sectors the engine sits in a busy phase whose length the host can program.

The drive side is a byte-serial request/acknowledge port to a backing store. The engine presents the drive, the sector LBA and the byte offset, then moves one byte per acknowledge. A read command first fetches the first sector before any data is offered to the host. A write command moves each sector to the store after the host has filled it. Completion of every busy phase can raise an interrupt. The interrupt can be masked, and it is cleared by the rules listed below.

Top module: `pio_sector_ctrl`

## Requirements
- R1: After reset the status byte reads 0x40, `irq_o`, `cmd_err_o` and `proto_err_o` are low, and the task-file registers read 0x00.
- R2: Writing 0x20 or 0x21 to register 7 starts a multi-sector read, and writing 0x30 or 0x31 starts a multi-sector write. Any other code written in the idle state changes nothing: the status stays 0x40, no drive request occurs and no interrupt is raised.
- R3: A command written while the engine is not idle is ignored, and it sets the sticky `cmd_err_o`.
- R4: The sector count comes from register 2, and a value of 0 means 256 sectors.
- R5: The starting LBA is {reg6[3:0], reg5, reg4, reg3}, and reg6 bit 4 selects the drive. Each sector moved on the drive port advances the LBA by one. Within a sector, bytes move at offsets 0 to SECT_BYTES-1.
- R6: The status byte (register 7, or alternate register 8) reads 0x08 while loading or draining, 0x80 while busy, and 0x40 when idle.
- R7: A read fetches its first sector before it shows data request. The whole read fetches exactly N sectors, and the host drains the bytes in stored order.
- R8: A write fills the buffer from the data port. After the last byte of a sector, the buffer goes to the store at the current LBA. N sectors are written in all.
- R9: Once a sector move on the drive port ends, the engine stays busy for `ready_dly_i`+1 cycles. It then leaves busy (to load/drain if sectors remain, otherwise to idle) and requests an interrupt.
- R10: An interrupt is raised only while control bit 1 (register 8, write) is clear. A status read (register 7) clears a pending interrupt, an alternate status read does not, and a control write with bit 1 set clears it.
- R11: A data-port access outside the load or drain state sets the sticky `proto_err_o`. A read in that case returns 0x00, and a write leaves the buffer and its position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Host read strobe, one cycle |
| wr_i | input | 1 | Host write strobe, one cycle |
| addr_i | input | 4 | Register select: 0 data, 1 feature, 2 count, 3-5 LBA bytes, 6 device/head, 7 status/command, 8 alt status/control |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid the cycle after `rd_i` |
| ready_dly_i | input | DLY_W | Busy delay between sectors, in cycles |
| irq_o | output | 1 | Interrupt request |
| cmd_err_o | output | 1 | Sticky: command issued while not idle |
| proto_err_o | output | 1 | Sticky: data port accessed in the wrong state |
| dev_req_o | output | 1 | Drive-side byte transfer request |
| dev_we_o | output | 1 | 1 for a store write, 0 for a fetch |
| dev_drv_o | output | 1 | Selected drive |
| dev_lba_o | output | 28 | Sector LBA of the current move |
| dev_off_o | output | $clog2(SECT_BYTES) | Byte offset in the sector |
| dev_wdata_o | output | 8 | Byte to store |
| dev_ack_i | input | 1 | Drive-side acknowledge, one byte per cycle |
| dev_rdata_i | input | 8 | Fetched byte, valid with `dev_ack_i` |

## Verification
A wrong sequencer state shows up at the next alternate-status read, one cycle after the strobe, as the wrong status code. A lost or extra sector count shows up as a wrong number of drive-port bytes, or as a final LBA that differs from start + N - 1. A corrupt buffer pointer or a missing priming fetch shows up as byte mismatches in the first drained sector. An off-by-one in the delay counter shifts the interrupt rise by one cycle relative to the end of the drive-port move.

// File: rtl/pio_ctrl_pkg.sv
package pio_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_DRAIN,
    S_BUSY_L,
    S_BUSY_D
  } seq_state_e;

  localparam logic [3:0] A_DATA = 4'd0;
  localparam logic [3:0] A_FEAT = 4'd1;
  localparam logic [3:0] A_CNT  = 4'd2;
  localparam logic [3:0] A_LBA0 = 4'd3;
  localparam logic [3:0] A_LBA1 = 4'd4;
  localparam logic [3:0] A_LBA2 = 4'd5;
  localparam logic [3:0] A_DEVH = 4'd6;
  localparam logic [3:0] A_STAT = 4'd7;
  localparam logic [3:0] A_ALT  = 4'd8;

  localparam logic [7:0] STAT_DRQ = 8'h08;
  localparam logic [7:0] STAT_BSY = 8'h80;
  localparam logic [7:0] STAT_RDY = 8'h40;

  function automatic logic [7:0] status_of(seq_state_e s);
    case (s)
      S_LOAD, S_DRAIN:     return STAT_DRQ;
      S_BUSY_L, S_BUSY_D:  return STAT_BSY;
      default:             return STAT_RDY;
    endcase
  endfunction

endpackage

// File: rtl/pio_taskfile.sv
module pio_taskfile
  import pio_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic [7:0]  status_i,
  input  logic [7:0]  data_i,
  output logic [7:0]  rd_byte_o,
  output logic [7:0]  cnt_o,
  output logic [27:0] lba_o,
  output logic        drv_o,
  output logic        nien_o
);

  logic [7:0] feat_q, cnt_q, lba0_q, lba1_q, lba2_q, devh_q, ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      feat_q <= '0;
      cnt_q  <= '0;
      lba0_q <= '0;
      lba1_q <= '0;
      lba2_q <= '0;
      devh_q <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_FEAT: feat_q <= wdata_i;
        A_CNT:  cnt_q  <= wdata_i;
        A_LBA0: lba0_q <= wdata_i;
        A_LBA1: lba1_q <= wdata_i;
        A_LBA2: lba2_q <= wdata_i;
        A_DEVH: devh_q <= wdata_i;
        A_ALT:  ctrl_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_DATA:        rd_byte_o = data_i;
      A_FEAT:        rd_byte_o = feat_q;
      A_CNT:         rd_byte_o = cnt_q;
      A_LBA0:        rd_byte_o = lba0_q;
      A_LBA1:        rd_byte_o = lba1_q;
      A_LBA2:        rd_byte_o = lba2_q;
      A_DEVH:        rd_byte_o = devh_q;
      A_STAT, A_ALT: rd_byte_o = status_i;
      default:       rd_byte_o = 8'h00;
    endcase
  end

  assign cnt_o  = cnt_q;
  assign lba_o  = {devh_q[3:0], lba2_q, lba1_q, lba0_q};
  assign drv_o  = devh_q[4];
  assign nien_o = ctrl_q[1];

endmodule

// File: rtl/pio_sect_buf.sv
module pio_sect_buf #(
  parameter int DEPTH = 16,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [7:0]              wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][7:0]     rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end

endmodule

// File: rtl/pio_irq.sv
module pio_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic nien_i,
  input  logic stat_rd_i,
  input  logic ctrl_clr_i,
  output logic irq_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   irq_o <= 1'b0;
    else if (fire_i && !nien_i)    irq_o <= 1'b1;
    else if (stat_rd_i || ctrl_clr_i) irq_o <= 1'b0;
  end

endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_ctrl_pkg::*;
#(
  parameter int SECT_BYTES = 16,
  parameter int DLY_W      = 8,
  localparam int PW        = $clog2(SECT_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_go_i,
  input  logic [7:0]       cmd_code_i,
  input  logic [7:0]       cnt_i,
  input  logic [27:0]      lba_i,
  input  logic             drv_i,
  input  logic             data_wr_i,
  input  logic             data_rd_i,
  input  logic [7:0]       host_wdata_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             dev_ack_i,
  input  logic [7:0]       dev_rdata_i,
  output seq_state_e       state_o,
  output logic [PW-1:0]    pos_o,
  output logic [PW-1:0]    mv_o,
  output logic             buf_we_o,
  output logic [PW-1:0]    buf_waddr_o,
  output logic [7:0]       buf_wdata_o,
  output logic             dev_req_o,
  output logic             dev_we_o,
  output logic             dev_drv_o,
  output logic [27:0]      dev_lba_o,
  output logic             fire_o,
  output logic             cmd_err_o,
  output logic             proto_err_o
);

  localparam logic [PW-1:0] LAST = PW'(SECT_BYTES - 1);

  seq_state_e       state_q;
  logic [8:0]       rem_q;
  logic [PW-1:0]    pos_q, mv_q;
  logic [27:0]      lba_q;
  logic             drv_q, moving_q, cmd_err_q, proto_q;
  logic [DLY_W-1:0] dly_q;

  logic busy, is_rd, is_wr;
  logic [8:0] cnt_n;

  assign busy   = (state_q == S_BUSY_L) || (state_q == S_BUSY_D);
  assign is_rd  = (cmd_code_i[7:1] == 7'h10);
  assign is_wr  = (cmd_code_i[7:1] == 7'h18);
  assign cnt_n  = (cnt_i == 8'd0) ? 9'd256 : {1'b0, cnt_i};
  assign fire_o = busy && !moving_q && (dly_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      rem_q     <= '0;
      pos_q     <= '0;
      mv_q      <= '0;
      lba_q     <= '0;
      drv_q     <= 1'b0;
      moving_q  <= 1'b0;
      dly_q     <= '0;
      cmd_err_q <= 1'b0;
      proto_q   <= 1'b0;
    end else begin
      if (cmd_go_i) begin
        if (state_q != S_IDLE) begin
          cmd_err_q <= 1'b1;
        end else if (is_rd || is_wr) begin
          rem_q <= cnt_n;
          lba_q <= lba_i;
          drv_q <= drv_i;
          pos_q <= '0;
          if (is_rd) begin
            // priming fetch of the first sector
            state_q  <= S_BUSY_D;
            moving_q <= 1'b1;
            mv_q     <= '0;
          end else begin
            state_q <= S_LOAD;
          end
        end
      end
      if ((data_wr_i && state_q != S_LOAD) || (data_rd_i && state_q != S_DRAIN))
        proto_q <= 1'b1;

      case (state_q)
        S_LOAD: if (data_wr_i) begin
          if (pos_q == LAST) begin
            pos_q    <= '0;
            rem_q    <= rem_q - 9'd1;
            state_q  <= S_BUSY_L;
            moving_q <= 1'b1;
            mv_q     <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        S_DRAIN: if (data_rd_i) begin
          if (pos_q == LAST) begin
            pos_q   <= '0;
            rem_q   <= rem_q - 9'd1;
            state_q <= S_BUSY_D;
            if (rem_q > 9'd1) begin
              moving_q <= 1'b1;
              mv_q     <= '0;
            end else begin
              moving_q <= 1'b0;
              dly_q    <= dly_i;
            end
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        S_BUSY_L, S_BUSY_D: begin
          if (moving_q) begin
            if (dev_ack_i) begin
              if (mv_q == LAST) begin
                moving_q <= 1'b0;
                dly_q    <= dly_i;
                lba_q    <= lba_q + 28'd1;
              end else begin
                mv_q <= mv_q + 1'b1;
              end
            end
          end else if (dly_q == '0) begin
            pos_q <= '0;
            if (rem_q != 9'd0)
              state_q <= (state_q == S_BUSY_L) ? S_LOAD : S_DRAIN;
            else
              state_q <= S_IDLE;
          end else begin
            dly_q <= dly_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign state_o     = state_q;
  assign pos_o       = pos_q;
  assign mv_o        = mv_q;
  assign dev_req_o   = busy && moving_q;
  assign dev_we_o    = (state_q == S_BUSY_L);
  assign dev_drv_o   = drv_q;
  assign dev_lba_o   = lba_q;
  assign cmd_err_o   = cmd_err_q;
  assign proto_err_o = proto_q;

  always_comb begin
    buf_we_o    = 1'b0;
    buf_waddr_o = pos_q;
    buf_wdata_o = host_wdata_i;
    if (state_q == S_LOAD && data_wr_i) begin
      buf_we_o = 1'b1;
    end else if (state_q == S_BUSY_D && moving_q && dev_ack_i) begin
      buf_we_o    = 1'b1;
      buf_waddr_o = mv_q;
      buf_wdata_o = dev_rdata_i;
    end
  end

endmodule

// File: rtl/pio_sector_ctrl.sv
module pio_sector_ctrl
  import pio_ctrl_pkg::*;
#(
  parameter int SECT_BYTES = 16,
  parameter int DLY_W      = 8,
  localparam int PW        = $clog2(SECT_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [3:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic [DLY_W-1:0] ready_dly_i,
  output logic             irq_o,
  output logic             cmd_err_o,
  output logic             proto_err_o,
  output logic             dev_req_o,
  output logic             dev_we_o,
  output logic             dev_drv_o,
  output logic [27:0]      dev_lba_o,
  output logic [PW-1:0]    dev_off_o,
  output logic [7:0]       dev_wdata_o,
  input  logic             dev_ack_i,
  input  logic [7:0]       dev_rdata_i
);

  seq_state_e        state;
  logic [PW-1:0]     pos, mv, buf_waddr;
  logic              buf_we, fire, nien, drv;
  logic [7:0]        buf_wdata, cnt, rd_byte, data_byte, rdata_q;
  logic [27:0]       lba;
  logic [1:0][PW-1:0] buf_raddr;
  logic [1:0][7:0]   buf_rdata;

  logic cmd_go, data_wr, data_rd, stat_rd, ctrl_clr;
  assign cmd_go   = wr_i && (addr_i == A_STAT);
  assign data_wr  = wr_i && (addr_i == A_DATA);
  assign data_rd  = rd_i && (addr_i == A_DATA);
  assign stat_rd  = rd_i && (addr_i == A_STAT);
  assign ctrl_clr = wr_i && (addr_i == A_ALT) && wdata_i[1];

  pio_taskfile u_tf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .status_i  (status_of(state)),
    .data_i    (data_byte),
    .rd_byte_o (rd_byte),
    .cnt_o     (cnt),
    .lba_o     (lba),
    .drv_o     (drv),
    .nien_o    (nien)
  );

  pio_seq #(.SECT_BYTES(SECT_BYTES), .DLY_W(DLY_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_go_i     (cmd_go),
    .cmd_code_i   (wdata_i),
    .cnt_i        (cnt),
    .lba_i        (lba),
    .drv_i        (drv),
    .data_wr_i    (data_wr),
    .data_rd_i    (data_rd),
    .host_wdata_i (wdata_i),
    .dly_i        (ready_dly_i),
    .dev_ack_i    (dev_ack_i),
    .dev_rdata_i  (dev_rdata_i),
    .state_o      (state),
    .pos_o        (pos),
    .mv_o         (mv),
    .buf_we_o     (buf_we),
    .buf_waddr_o  (buf_waddr),
    .buf_wdata_o  (buf_wdata),
    .dev_req_o    (dev_req_o),
    .dev_we_o     (dev_we_o),
    .dev_drv_o    (dev_drv_o),
    .dev_lba_o    (dev_lba_o),
    .fire_o       (fire),
    .cmd_err_o    (cmd_err_o),
    .proto_err_o  (proto_err_o)
  );

  assign buf_raddr[0] = pos;
  assign buf_raddr[1] = mv;

  pio_sect_buf #(.DEPTH(SECT_BYTES), .NRD(2)) u_buf (
    .clk_i   (clk_i),
    .we_i    (buf_we),
    .waddr_i (buf_waddr),
    .wdata_i (buf_wdata),
    .raddr_i (buf_raddr),
    .rdata_o (buf_rdata)
  );

  pio_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .nien_i     (nien),
    .stat_rd_i  (stat_rd),
    .ctrl_clr_i (ctrl_clr),
    .irq_o      (irq_o)
  );

  assign data_byte   = (state == S_DRAIN) ? buf_rdata[0] : 8'h00;
  assign dev_off_o   = mv;
  assign dev_wdata_o = buf_rdata[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rd_byte;
  end
  assign rdata_o = rdata_q;

endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk
  import pio_ctrl_pkg::*;
#(
  parameter int PW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          wr_i,
  input logic [3:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic          irq_o,
  input logic          nien,
  input logic          fire,
  input logic [2:0]    state,
  input logic          cmd_err_o,
  input logic          proto_err_o,
  input logic          dev_req_o,
  input logic          dev_ack_i,
  input logic [PW-1:0] dev_off_o,
  input logic [27:0]   dev_lba_o
);

  a_r10_masked_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$past(nien));

  a_r10_status_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_STAT && !fire) |=> !irq_o);

  a_r10_alt_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == A_ALT && irq_o) |=> irq_o);

  a_r10_ctrl_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_ALT && wdata_i[1] && !fire) |=> !irq_o);

  a_r3_cmd_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_STAT && state != 3'(S_IDLE)) |=> cmd_err_o);

  a_r3_cmd_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> cmd_err_o);

  a_r11_proto_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

  a_r11_data_wrong_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_DATA && state != 3'(S_DRAIN)) |=> proto_err_o);

  a_r5_dev_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_req_o && !dev_ack_i) |=> (dev_req_o && $stable(dev_off_o) && $stable(dev_lba_o)));

endmodule

bind pio_sector_ctrl pio_ctrl_chk #(.PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .irq_o       (irq_o),
  .nien        (nien),
  .fire        (fire),
  .state       (state),
  .cmd_err_o   (cmd_err_o),
  .proto_err_o (proto_err_o),
  .dev_req_o   (dev_req_o),
  .dev_ack_i   (dev_ack_i),
  .dev_off_o   (dev_off_o),
  .dev_lba_o   (dev_lba_o)
);

// File: tb/pio_sector_ctrl_bench.sv
module pio_sector_ctrl_bench;

  localparam int SB = 16;
  localparam int PW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  ready_dly = 8'd2;
  logic        irq, cmd_err, proto_err;
  logic        dev_req, dev_we, dev_drv;
  logic [27:0] dev_lba;
  logic [PW-1:0] dev_off;
  logic [7:0]  dev_wdata;
  logic        dev_ack = 1'b0;
  logic [7:0]  dev_rdata = '0;

  always #5 clk = ~clk;

  pio_sector_ctrl #(.SECT_BYTES(SB), .DLY_W(8)) u_pio_sector_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_dly_i(ready_dly), .irq_o(irq),
    .cmd_err_o(cmd_err), .proto_err_o(proto_err), .dev_req_o(dev_req),
    .dev_we_o(dev_we), .dev_drv_o(dev_drv), .dev_lba_o(dev_lba),
    .dev_off_o(dev_off), .dev_wdata_o(dev_wdata), .dev_ack_i(dev_ack),
    .dev_rdata_i(dev_rdata)
  );

  int total = 0, bad = 0;
  logic [7:0] devmem [int];
  logic [7:0] expmem [int];
  int wr_bytes = 0, rd_bytes = 0;
  logic [27:0] last_wr_lba = '0;
  bit req_seen = 0, irq_seen = 0;

  function automatic int key(bit d, logic [27:0] l, int off);
    return int'({d, l[27:24], l[11:0], off[3:0]});
  endfunction

  function automatic logic [7:0] pat(int k);
    return 8'(k * 13 + 7);
  endfunction

  function automatic logic [7:0] expect_byte(int k);
    return expmem.exists(k) ? expmem[k] : pat(k);
  endfunction

  // backing store model, answers at the falling edge
  always @(negedge clk) begin
    if (dev_req) req_seen = 1;
    if (irq) irq_seen = 1;
    if (rst_n && dev_req && ($urandom % 4 != 0)) begin
      automatic int k = key(dev_drv, dev_lba, int'(dev_off));
      dev_ack = 1'b1;
      if (dev_we) begin
        devmem[k] = dev_wdata;
        wr_bytes++;
        last_wr_lba = dev_lba;
      end else begin
        dev_rdata = devmem.exists(k) ? devmem[k] : pat(k);
        rd_bytes++;
      end
    end else begin
      dev_ack = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_alt(input logic [7:0] exp, input string req);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 6000; i++) begin
      host_rd(4'd8, s);
      if (s == exp) break;
    end
    check(s == exp, req, s, exp);
  endtask

  task automatic setup(input bit d, input logic [27:0] l, input int n);
    host_wr(4'd2, 8'(n));
    host_wr(4'd3, l[7:0]);
    host_wr(4'd4, l[15:8]);
    host_wr(4'd5, l[23:16]);
    host_wr(4'd6, {3'b111, d, l[27:24]});
  endtask

  task automatic load_sector(input bit d, input logic [27:0] l);
    for (int b = 0; b < SB; b++) begin
      automatic logic [7:0] v = 8'($urandom);
      host_wr(4'd0, v);
      expmem[key(d, l, b)] = v;
    end
  endtask

  task automatic drain_sector(input bit d, input logic [27:0] l, inout int mism,
                              inout int fa, inout int fe);
    logic [7:0] v;
    for (int b = 0; b < SB; b++) begin
      host_rd(4'd0, v);
      if (v != expect_byte(key(d, l, b))) begin
        if (mism == 0) begin fa = v; fe = expect_byte(key(d, l, b)); end
        mism++;
      end
    end
  endtask

  task automatic do_write(input bit d, input logic [27:0] l, input int n, input logic [7:0] code);
    setup(d, l, n);
    host_wr(4'd7, code);
    for (int s = 0; s < n; s++) begin
      wait_alt(8'h08, "R8 load ready");
      load_sector(d, l + 28'(s));
    end
    wait_alt(8'h40, "R8 write done");
  endtask

  task automatic do_read(input bit d, input logic [27:0] l, input int n, input logic [7:0] code,
                         input string req);
    int mism = 0, fa = 0, fe = 0;
    setup(d, l, n);
    host_wr(4'd7, code);
    for (int s = 0; s < n; s++) begin
      wait_alt(8'h08, "R7 drain ready");
      drain_sector(d, l + 28'(s), mism, fa, fe);
    end
    wait_alt(8'h40, "R7 read done");
    check(mism == 0, req, fa, fe);
  endtask

  task automatic measure_delay(input logic [7:0] dly, input int exp);
    logic [7:0] s;
    int n, mism = 0, fa = 0, fe = 0;
    ready_dly = dly;
    host_rd(4'd7, s);
    setup(1'b0, 28'd50, 2);
    host_wr(4'd7, 8'h20);
    while (!dev_req) @(negedge clk);
    while (dev_req) @(negedge clk);
    n = 0;
    while (!irq && n < 1000) begin n++; @(negedge clk); end
    check(n == exp, "R9 busy delay cycles", n, exp);
    for (int sct = 0; sct < 2; sct++) begin
      wait_alt(8'h08, "R9 drain ready");
      drain_sector(1'b0, 28'd50 + 28'(sct), mism, fa, fe);
    end
    wait_alt(8'h40, "R9 back to idle");
    check(mism == 0, "R9 data after delay", fa, fe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int wb, rb, mism, fa, fe;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    host_rd(4'd8, s);  check(s == 8'h40, "R1 reset status", s, 8'h40);
    host_rd(4'd2, s);  check(s == 8'h00, "R1 reset count reg", s, 0);
    host_rd(4'd6, s);  check(s == 8'h00, "R1 reset device reg", s, 0);
    check({irq, cmd_err, proto_err} == 3'b000, "R1 reset flags", {irq, cmd_err, proto_err}, 0);

    // R2 unknown code ignored
    req_seen = 0;
    host_wr(4'd7, 8'h50);
    repeat (20) @(negedge clk);
    host_rd(4'd8, s);
    check(s == 8'h40, "R2 unknown command status", s, 8'h40);
    check(!req_seen && !irq, "R2 unknown command activity", {req_seen, irq}, 0);

    // R8 / R5 three-sector write
    wb = wr_bytes;
    do_write(1'b0, 28'd10, 3, 8'h30);
    check(wr_bytes - wb == 3 * SB, "R8 bytes stored", wr_bytes - wb, 3 * SB);
    check(last_wr_lba == 28'd12, "R5 final write lba", last_wr_lba, 12);

    // R7 read back, N fetches with priming
    rb = rd_bytes;
    do_read(1'b0, 28'd10, 3, 8'h20, "R7 read data");
    check(rd_bytes - rb == 3 * SB, "R7 fetch count", rd_bytes - rb, 3 * SB);

    // R5 drive select and high LBA nibble, alternate codes
    do_write(1'b1, 28'd10, 1, 8'h31);
    do_read(1'b1, 28'd10, 1, 8'h21, "R5 drive1 data");
    do_read(1'b0, 28'd10, 1, 8'h21, "R5 drive0 untouched");
    do_write(1'b0, 28'h300_0007, 1, 8'h30);
    do_read(1'b0, 28'd7, 1, 8'h20, "R5 low lba untouched");
    do_read(1'b0, 28'h300_0007, 1, 8'h20, "R5 high lba data");

    // R6 status codes through a one-sector read
    mism = 0; fa = 0; fe = 0;
    setup(1'b0, 28'd60, 1);
    host_wr(4'd7, 8'h20);
    host_rd(4'd8, s);  check(s == 8'h80, "R6 busy during priming", s, 8'h80);
    wait_alt(8'h08, "R6 data request");
    drain_sector(1'b0, 28'd60, mism, fa, fe);
    host_rd(4'd8, s);  check(s == 8'h80, "R6 busy after last byte", s, 8'h80);
    wait_alt(8'h40, "R6 ready");
    check(mism == 0, "R6 data", fa, fe);

    // R9 busy delay
    measure_delay(8'd5, 6);
    measure_delay(8'd0, 1);
    ready_dly = 8'd2;

    // R10 interrupt rules
    host_wr(4'd8, 8'h02);
    host_rd(4'd7, s);
    irq_seen = 0;
    do_write(1'b0, 28'd30, 1, 8'h30);
    check(!irq_seen, "R10 masked no irq", irq_seen, 0);
    host_wr(4'd8, 8'h00);
    mism = 0;
    setup(1'b0, 28'd30, 1);
    host_wr(4'd7, 8'h20);
    wait_alt(8'h08, "R10 drain ready");
    check(irq == 1'b1, "R10 irq raised", irq, 1);
    host_rd(4'd8, s);
    check(irq == 1'b1, "R10 alt read keeps irq", irq, 1);
    host_rd(4'd7, s);
    check(s == 8'h08 && irq == 1'b0, "R10 status read clears", {s, irq}, {8'h08, 1'b0});
    drain_sector(1'b0, 28'd30, mism, fa, fe);
    wait_alt(8'h40, "R10 idle");
    check(mism == 0, "R10 data", fa, fe);
    check(irq == 1'b1, "R10 irq at end", irq, 1);
    host_wr(4'd8, 8'h02);
    check(irq == 1'b0, "R10 control clears", irq, 0);
    host_wr(4'd8, 8'h00);

    // R3 command while loading
    setup(1'b0, 28'd40, 1);
    host_wr(4'd7, 8'h30);
    wait_alt(8'h08, "R3 loading");
    check(cmd_err == 1'b0, "R3 no error before", cmd_err, 0);
    host_wr(4'd7, 8'h20);
    check(cmd_err == 1'b1, "R3 error flagged", cmd_err, 1);
    host_rd(4'd8, s);  check(s == 8'h08, "R3 state unchanged", s, 8'h08);
    load_sector(1'b0, 28'd40);
    wait_alt(8'h40, "R3 write done");
    do_read(1'b0, 28'd40, 1, 8'h20, "R3 data intact");

    // R11 wrong-state data access
    host_rd(4'd0, s);
    check(s == 8'h00 && proto_err, "R11 idle data read", {s, proto_err}, {8'h00, 1'b1});
    mism = 0;
    setup(1'b0, 28'd20, 1);
    host_wr(4'd7, 8'h20);
    wait_alt(8'h08, "R11 drain ready");
    host_wr(4'd0, 8'hA5);
    drain_sector(1'b0, 28'd20, mism, fa, fe);
    wait_alt(8'h40, "R11 idle");
    check(mism == 0, "R11 write ignored", fa, fe);

    // R4 count zero means 256
    ready_dly = 8'd0;
    wb = wr_bytes;
    do_write(1'b0, 28'd100, 256, 8'h30);
    check(wr_bytes - wb == 256 * SB, "R4 256 sectors", wr_bytes - wb, 256 * SB);
    check(last_wr_lba == 28'd355, "R4 last lba", last_wr_lba, 355);
    do_read(1'b0, 28'd300, 8, 8'h20, "R4 readback");

    // random mix (R7 R8)
    ready_dly = 8'd3;
    for (int it = 0; it < 6; it++) begin
      automatic bit d = 1'($urandom);
      automatic logic [27:0] l = 28'(400 + $urandom % 2000);
      automatic int n = 1 + int'($urandom % 4);
      do_write(d, l, n, ($urandom % 2) ? 8'h31 : 8'h30);
      do_read(d, l, n, ($urandom % 2) ? 8'h21 : 8'h20, "R7 random readback");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule